// File: doc/BRIEF.md
# Shopping Item List with Slot Recycling

This block keeps the identifiers of the items a shopper has scanned during one session. The identifiers sit in a flop array of `DEPTH` entries, each `IDW` bits wide. An entry value of zero means the slot is empty, so valid item IDs run from 1 to 2^IDW-1. New items go into a sequential region at an incrementing write pointer.

Removing an item is done by naming its ID, not its address. The block scans the array upward from address 0, one address per cycle, and stops at the first entry that holds that ID. It clears that entry and pushes its address onto a last-in-first-out stack of free slots. When the sequential region is used up, new items are placed at addresses popped from that stack.

A list command streams every entry out, one per cycle, with its address, so that a display can show the basket. A clear command ends the session and empties everything in one cycle. The host issues only one request per cycle. `done` marks the end of each accepted operation.

Top module: `cart_item_store`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `full`, `add_err` and `list_valid` are low, and every entry reads back as 0.
- R2: An `add_req` with a nonzero ID in idle while `full` is low writes the ID at the write pointer. One cycle later `done` pulses and `slot_addr` shows that address. The pointer then advances by one.
- R3: `full` rises once the write pointer reaches DEPTH-1, which happens after DEPTH-1 sequential adds (addresses 0 to DEPTH-2). It stays high until a clear.
- R4: While `full` is high, an add takes its address from the top of the free-slot stack, so the most recently freed slot is used first. Popping the last stack entry leaves the stack empty.
- R5: An add with ID 0, or an add while `full` is high and the stack is empty, pulses `add_err` for one cycle instead of `done`. Nothing is written.
- R6: A remove with a nonzero ID raises `busy` and examines address k in the (k+1)-th cycle after the request. On the lowest matching address k, `done` and `found` pulse together k+2 cycles after the request, `slot_addr` shows k, and `busy` falls in that cycle.
- R7: The matched entry becomes 0 and its address is pushed onto the free-slot stack. A push onto an empty stack fills position 0.
- R8: A remove that finds no match ends with `done` high and `found` low DEPTH+1 cycles after the request, and nothing changes. A remove of ID 0 ends this way one cycle after the request.
- R9: A list request raises `list_valid` for DEPTH cycles, beginning the cycle after the request. In cycle j, `slot_addr` is j and `list_id` is the content of entry j. `done` pulses in the cycle that follows.
- R10: A clear request sets every entry to 0, resets the write pointer, empties the stack and pulses `done` one cycle later.
- R11: Requests that arrive while `busy` is high are ignored. When several requests arrive together in idle, clear wins, then remove, then list, then add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_req | input | 1 | Store `item_id` in a free slot |
| remove_req | input | 1 | Search for `item_id` and free its slot |
| list_req | input | 1 | Stream all entries out |
| clear_req | input | 1 | End the session and empty everything |
| item_id | input | IDW | Item ID used by add and remove |
| busy | output | 1 | A search or a list is running |
| done | output | 1 | One-cycle pulse at the end of an accepted operation |
| found | output | 1 | Pulses with `done` when a remove matched |
| full | output | 1 | The sequential region is used up |
| add_err | output | 1 | One-cycle pulse when an add is rejected |
| slot_addr | output | $clog2(DEPTH) | Address written or matched, or the list index while listing |
| list_valid | output | 1 | `list_id` holds an entry |
| list_id | output | IDW | Entry content during a list |

## Verification
Directed cases place matches at the lowest address, at a middle address and nowhere. Each case gives a distinct completion latency, which separates an off-by-one scan from a correct one. A fill to the full mark, followed by two removals and three adds, tells a LIFO stack from a FIFO one and checks the empty-stack rejection. Randomized sequences use a small ID alphabet, so duplicates are common. This shows whether the lowest match is always the one chosen and whether recycled slots land where the model expects. Requests sent during a search, and simultaneous clear and add, show that the priority order and the busy lockout are respected.

// File: rtl/cart_item_store.sv
module cart_item_store #(
  parameter int DEPTH = 100,
  parameter int IDW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add_req,
  input  logic remove_req,
  input  logic list_req,
  input  logic clear_req,
  input  logic [IDW-1:0] item_id,
  output logic busy,
  output logic done,
  output logic found,
  output logic full,
  output logic add_err,
  output logic [$clog2(DEPTH)-1:0] slot_addr,
  output logic list_valid,
  output logic [IDW-1:0] list_id
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_LIST} st_t;

  st_t st;
  logic [IDW-1:0] mem [DEPTH];
  logic [AW-1:0] stk [DEPTH];
  logic [AW-1:0] wr_ptr, sp, idx, addr_q;
  logic [IDW-1:0] key;
  logic stk_empty;

  wire idle = (st == S_IDLE);
  wire hit = (mem[idx] == key);
  wire at_last = (idx == LAST);
  wire [AW-1:0] push_at = stk_empty ? '0 : sp + 1'b1;

  assign full = (wr_ptr == LAST);
  assign busy = !idle;
  assign list_valid = (st == S_LIST);
  assign list_id = list_valid ? mem[idx] : '0;
  assign slot_addr = list_valid ? idx : addr_q;

  always_ff @(posedge clk) begin
    if (st == S_SEARCH && hit) stk[push_at] <= idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wr_ptr <= '0;
      sp <= '0;
      idx <= '0;
      addr_q <= '0;
      key <= '0;
      stk_empty <= 1'b1;
      done <= 1'b0;
      found <= 1'b0;
      add_err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      done <= 1'b0;
      found <= 1'b0;
      add_err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (clear_req) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr <= '0;
            sp <= '0;
            stk_empty <= 1'b1;
            done <= 1'b1;
          end else if (remove_req) begin
            if (item_id == '0) begin
              done <= 1'b1;
            end else begin
              key <= item_id;
              idx <= '0;
              st <= S_SEARCH;
            end
          end else if (list_req) begin
            idx <= '0;
            st <= S_LIST;
          end else if (add_req) begin
            if (item_id == '0) begin
              add_err <= 1'b1;
            end else if (!full) begin
              mem[wr_ptr] <= item_id;
              addr_q <= wr_ptr;
              wr_ptr <= wr_ptr + 1'b1;
              done <= 1'b1;
            end else if (!stk_empty) begin
              mem[stk[sp]] <= item_id;
              addr_q <= stk[sp];
              if (sp == '0) stk_empty <= 1'b1;
              else sp <= sp - 1'b1;
              done <= 1'b1;
            end else begin
              add_err <= 1'b1;
            end
          end
        end
        S_SEARCH: begin
          if (hit) begin
            mem[idx] <= '0;
            addr_q <= idx;
            found <= 1'b1;
            done <= 1'b1;
            if (stk_empty) stk_empty <= 1'b0;
            else sp <= sp + 1'b1;
            st <= S_IDLE;
          end else if (at_last) begin
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_LIST: begin
          if (at_last) begin
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_found_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done);

  p_err_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    add_err |-> !done);

  p_full_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(idle && clear_req)) |=> full);

  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && clear_req) |=> (!full && done && !busy));

  p_list_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (list_valid && $past(list_valid)) |-> (slot_addr == $past(slot_addr) + 1'b1));

  p_busy_no_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !add_err);
endmodule

// File: tb/cart_item_store_tb.sv
`timescale 1ns/1ps
module cart_item_store_tb;
  localparam int DEPTH = 100;
  localparam int IDW = 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic add_req = 1'b0, remove_req = 1'b0, list_req = 1'b0, clear_req = 1'b0;
  logic [IDW-1:0] item_id = '0;
  logic busy, done, found, full, add_err, list_valid;
  logic [AW-1:0] slot_addr;
  logic [IDW-1:0] list_id;

  cart_item_store #(.DEPTH(DEPTH), .IDW(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .add_req(add_req), .remove_req(remove_req),
    .list_req(list_req), .clear_req(clear_req), .item_id(item_id),
    .busy(busy), .done(done), .found(found), .full(full), .add_err(add_err),
    .slot_addr(slot_addr), .list_valid(list_valid), .list_id(list_id));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int m_mem[DEPTH];
  int m_stk[DEPTH];
  int m_ptr, m_sp;
  bit m_empty;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    m_ptr = 0; m_sp = 0; m_empty = 1;
  endtask

  task automatic do_add(int id);
    int exp_addr;
    string tag;
    @(negedge clk); item_id = IDW'(id); add_req = 1'b1;
    @(negedge clk); add_req = 1'b0;
    exp_addr = -1; tag = "R5";
    if (id != 0) begin
      if (m_ptr < DEPTH - 1) begin
        exp_addr = m_ptr; m_ptr++; tag = "R2";
      end else if (!m_empty) begin
        exp_addr = m_stk[m_sp]; tag = "R4";
        if (m_sp == 0) m_empty = 1; else m_sp--;
      end
    end
    if (exp_addr >= 0) begin
      m_mem[exp_addr] = id;
      chk(done && !add_err && slot_addr == AW'(exp_addr), tag, int'(slot_addr), exp_addr);
    end else begin
      chk(add_err && !done, tag, int'(add_err), 1);
    end
    chk(full == (m_ptr == DEPTH - 1), "R3", int'(full), int'(m_ptr == DEPTH - 1));
  endtask

  task automatic do_remove(int id);
    int k, c, exp_c;
    bit b1;
    k = -1;
    if (id != 0)
      for (int i = DEPTH - 1; i >= 0; i--) if (m_mem[i] == id) k = i;
    @(negedge clk); item_id = IDW'(id); remove_req = 1'b1;
    @(negedge clk); remove_req = 1'b0;
    c = 1; b1 = busy;
    while (!done && c < DEPTH + 5) begin
      @(negedge clk); c++;
    end
    if (id == 0) exp_c = 1;
    else if (k >= 0) exp_c = k + 2;
    else exp_c = DEPTH + 1;
    chk(c == exp_c, k >= 0 ? "R6" : "R8", c, exp_c);
    chk(found == (k >= 0) && !busy, k >= 0 ? "R6" : "R8", int'(found), int'(k >= 0));
    if (id != 0) chk(b1, "R6", int'(b1), 1);
    if (k >= 0) begin
      chk(slot_addr == AW'(k), "R6", int'(slot_addr), k);
      m_mem[k] = 0;
      if (m_empty) begin m_empty = 0; m_stk[0] = k; end
      else begin m_sp++; m_stk[m_sp] = k; end
    end
  endtask

  task automatic do_list(string tag);
    int bad, first_j, act, exp;
    bad = 0; first_j = -1; act = 0; exp = 0;
    @(negedge clk); list_req = 1'b1;
    @(negedge clk); list_req = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (!list_valid || slot_addr != AW'(j) || int'(list_id) != m_mem[j]) begin
        if (bad == 0) begin first_j = j; act = int'(list_id); exp = m_mem[j]; end
        bad++;
      end
      @(negedge clk);
    end
    chk(bad == 0, tag, act, exp);
    if (bad != 0) $display("  first mismatch at entry %0d", first_j);
    chk(done && !list_valid && !busy, "R9", int'(done), 1);
  endtask

  task automatic do_clear();
    @(negedge clk); clear_req = 1'b1;
    @(negedge clk); clear_req = 1'b0;
    m_clear();
    chk(done && !full && !busy, "R10", int'(full), 0);
  endtask

  initial begin
    int r, c;
    void'($urandom(32'd20240611));
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    r = {busy, done, found, full, add_err, list_valid};
    chk(r == 0, "R1", r, 0);
    do_list("R1");

    do_add(5); do_add(6); do_add(7); do_add(6);
    do_remove(6);
    do_remove(5);
    do_remove(200);
    do_remove(0);
    do_add(0);
    do_list("R9");

    while (m_ptr < DEPTH - 1) do_add((m_ptr % 200) + 10);
    do_add(33);
    do_add(34);
    do_remove(m_mem[20]);
    do_remove(m_mem[40]);
    do_add(41);
    do_add(42);
    do_add(43);
    do_list("R7");

    @(negedge clk); item_id = 8'd250; remove_req = 1'b1;
    @(negedge clk); remove_req = 1'b0; item_id = 8'd77; add_req = 1'b1; clear_req = 1'b1;
    @(negedge clk); add_req = 1'b0; clear_req = 1'b0;
    c = 2;
    while (!done && c < DEPTH + 5) begin @(negedge clk); c++; end
    chk(c == DEPTH + 1 && !found, "R11", c, DEPTH + 1);
    do_list("R11");

    @(negedge clk); item_id = 8'd9; add_req = 1'b1; clear_req = 1'b1;
    @(negedge clk); add_req = 1'b0; clear_req = 1'b0;
    m_clear();
    chk(done && !full, "R11", int'(full), 0);
    do_list("R10");

    do_add(3); do_add(4);
    do_clear();
    do_list("R10");

    for (int n = 0; n < 450; n++) begin
      r = $urandom_range(0, 9);
      if (r < 5) do_add($urandom_range(0, 12));
      else if (r < 8) do_remove($urandom_range(0, 12));
      else if (r == 8 && n % 3 == 0) do_list("R9");
      else if (n % 40 == 0) do_clear();
      else do_add($urandom_range(1, 12));
    end
    while (m_ptr < DEPTH - 1) do_add($urandom_range(1, 12));
    for (int n = 0; n < 30; n++) begin
      if (n % 2 == 0) do_remove($urandom_range(1, 12));
      else do_add($urandom_range(1, 12));
    end
    do_list("R4");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule